// File: doc/BRIEF.md
# DisplayPort AUX Snoop Lane Manager

This block sits beside a DisplayPort AUX channel and listens to requests travelling from source to sink. It never drives the channel. An upstream decoder has already framed the traffic into bytes. Each byte arrives with a valid strobe, a flag that marks the first byte of a request and a flag that marks its last byte. The block picks out native write requests and follows every data byte to the DPCD address that byte lands on. It keeps the most recent lane-count setting and the most recent sink power setting.

From those two stored values the block produces one registered enable per main-link lane. All lanes are switched off while the sink is in its deepest sleep state. Otherwise lane 0 upward is enabled up to the stored lane count.

A configuration input can take lane control away from the snooper. The lanes then copy a mask that firmware supplies.

Top module: `aux_lane_snoop`

## Requirements
- R1: After reset the stored lane count is the full lane count (4) and the sink is taken as awake, so `lane_en` reads 4'b1111. This holds both at start-up and after a reset applied mid-run.
- R2: A request is a native write when bits [7:4] of its first byte are 4'b1000.
  - The header is four bytes. Byte 0 bits [3:0] carry address bits [19:16]. Byte 1 carries address bits [15:8] and byte 2 carries bits [7:0]. Byte 3 carries the data count minus one.
  - A data byte written to address 0x00101 whose bits [4:0] are 1, 2 or 4 sets the lane count.
  - `lane_en` becomes 4'b0001, 4'b0011 or 4'b1111 respectively.
  - The new value appears on the second rising edge after the edge that samples the end-flagged byte, and `lane_en` is unchanged after the first of those edges.
- R3: A lane-count byte whose bits [4:0] are not 1, 2 or 4 is ignored and the previous count is kept. Bits [7:5] of that byte play no part.
- R4: A data byte written to address 0x00600 sets the power state from its bits [2:0].
  - A value of 2 or 5 means deep sleep, and all lanes are off whatever the lane count.
  - Any other value means awake, and the lanes follow the stored lane count.
  - A lane count written during deep sleep is kept and applied once the sink wakes.
- R5: The address advances by one for each data byte, so a multi-byte write that starts below a watched address and runs across it captures the byte that falls on that address. A write to a neighbouring address (for example 0x00102) changes nothing.
- R6: Requests whose command nibble is not 4'b1000 leave `lane_en` unchanged, even when they carry the watched addresses. This covers reads (4'b1001) and I2C-over-AUX writes (4'b0000).
- R7: Captured values take effect only when the end-flagged byte arrives. A request cut short by a new start-flagged byte before its end flag is discarded.
- R8: While `snoop_off` is high, `lane_en` copies `reg_lane_mask` one rising edge later. Writes seen while it is high are not stored. When it drops, `lane_en` returns to the state held before snooping was turned off, one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A request byte is present this cycle |
| rx_sot | input | 1 | Present byte is the first of a request (qualified by rx_valid) |
| rx_eot | input | 1 | Present byte is the last of a request (qualified by rx_valid) |
| rx_byte | input | 8 | Request byte |
| snoop_off | input | 1 | High hands lane control to reg_lane_mask |
| reg_lane_mask | input | 4 | Lane enables used while snooping is off |
| lane_en | output | 4 | Registered per-lane enables, bit 0 is lane 0 |

## Verification
The latency depends on the path.
- A committed write reaches `lane_en` two rising edges after the edge that samples its end-flagged byte. The first edge loads the stored settings and the second loads the output register.
- A change on `snoop_off` or `reg_lane_mask` shows up after one edge.
- Reset sets the output on the edge that samples it.

The bench drives on falling edges and samples on the falling edge after the due edge. In the R2 timing check it also samples one cycle earlier, to show the old value is still held. Checks for ignored traffic read `lane_en` at the same point a real update would have appeared.

// File: rtl/aux_snoop_pkg.sv
package aux_snoop_pkg;

  localparam int unsigned AUX_ADDR_W = 20;
  localparam int unsigned HDR_BYTES  = 4;
  localparam logic [3:0]  CMD_NATIVE_WR = 4'b1000;

  // lane count is legal when it is a nonzero power of two not above the lane total
  function automatic logic legal_count(input logic [4:0] v, input int unsigned lanes);
    logic ok;
    ok = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if ((int'(v) == (1 << i)) && ((1 << i) <= int'(lanes))) ok = 1'b1;
    end
    return ok;
  endfunction

  function automatic logic is_deep_sleep(input logic [2:0] s);
    return (s == 3'd2) || (s == 3'd5);
  endfunction

endpackage

// File: rtl/aux_req_parse.sv
module aux_req_parse
  import aux_snoop_pkg::*;
#(
  parameter logic [AUX_ADDR_W-1:0] LC_ADDR = 20'h00101,
  parameter logic [AUX_ADDR_W-1:0] PS_ADDR = 20'h00600,
  parameter int unsigned POS_W = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic       rx_sot,
  input  logic       rx_eot,
  input  logic [7:0] rx_byte,
  output logic       commit_lc_o,
  output logic [4:0] lc_val_o,
  output logic       commit_ps_o,
  output logic [2:0] ps_val_o
);

  logic                  open_q;
  logic [3:0]            cmd_q;
  logic [AUX_ADDR_W-1:0] addr_q;
  logic [7:0]            len_q;
  logic [POS_W-1:0]      pos_q;
  logic                  pend_lc_q, pend_ps_q;
  logic [4:0]            lc_q;
  logic [2:0]            ps_q;

  logic                  live, in_data, hit_lc, hit_ps;
  logic [POS_W-1:0]      pos, data_idx;
  logic [AUX_ADDR_W-1:0] cur_addr;

  always_comb begin
    live     = rx_valid && (rx_sot || open_q);
    pos      = rx_sot ? '0 : pos_q;
    data_idx = pos - POS_W'(HDR_BYTES);
    cur_addr = addr_q + AUX_ADDR_W'(data_idx);
    in_data  = live && !rx_sot && (pos >= POS_W'(HDR_BYTES)) &&
               (cmd_q == CMD_NATIVE_WR) && (data_idx <= POS_W'(len_q));
    hit_lc   = in_data && (cur_addr == LC_ADDR);
    hit_ps   = in_data && (cur_addr == PS_ADDR);

    commit_lc_o = live && rx_eot && (hit_lc || (!rx_sot && pend_lc_q));
    commit_ps_o = live && rx_eot && (hit_ps || (!rx_sot && pend_ps_q));
    lc_val_o    = hit_lc ? rx_byte[4:0] : lc_q;
    ps_val_o    = hit_ps ? rx_byte[2:0] : ps_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= 1'b0;
      cmd_q     <= '0;
      addr_q    <= '0;
      len_q     <= '0;
      pos_q     <= '0;
      pend_lc_q <= 1'b0;
      pend_ps_q <= 1'b0;
      lc_q      <= '0;
      ps_q      <= '0;
    end else if (rx_valid) begin
      if (live && rx_eot) begin
        open_q    <= 1'b0;
        pend_lc_q <= 1'b0;
        pend_ps_q <= 1'b0;
      end else if (rx_sot) begin
        open_q    <= 1'b1;
        cmd_q     <= rx_byte[7:4];
        addr_q    <= {rx_byte[3:0], 16'h0000};
        pos_q     <= POS_W'(1);
        pend_lc_q <= 1'b0;
        pend_ps_q <= 1'b0;
      end else if (open_q) begin
        case (pos_q)
          POS_W'(1): addr_q[15:8] <= rx_byte;
          POS_W'(2): addr_q[7:0]  <= rx_byte;
          POS_W'(3): len_q        <= rx_byte;
          default: ;
        endcase
        if (hit_lc) begin
          pend_lc_q <= 1'b1;
          lc_q      <= rx_byte[4:0];
        end
        if (hit_ps) begin
          pend_ps_q <= 1'b1;
          ps_q      <= rx_byte[2:0];
        end
        if (pos_q != '1) pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  // R6
  nonwrite_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_sot && open_q && cmd_q != CMD_NATIVE_WR) |-> !(commit_lc_o || commit_ps_o));

  // R7
  commit_needs_end_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_lc_o || commit_ps_o) |-> (rx_valid && rx_eot));

endmodule

// File: rtl/snoop_shadow.sv
module snoop_shadow
  import aux_snoop_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned CW = $clog2(LANES) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          commit_lc,
  input  logic [4:0]    lc_val,
  input  logic          commit_ps,
  input  logic [2:0]    ps_val,
  output logic [CW-1:0] lane_cnt_o,
  output logic          d3_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_cnt_o <= CW'(LANES);
      d3_o       <= 1'b0;
    end else if (!hold) begin
      if (commit_lc && legal_count(lc_val, LANES)) lane_cnt_o <= CW'(lc_val);
      if (commit_ps) d3_o <= is_deep_sleep(ps_val);
    end
  end

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !((commit_lc || commit_ps) && !hold) |=> ($stable(lane_cnt_o) && $stable(d3_o)));

  // R3
  legal_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    legal_count(5'(lane_cnt_o), LANES));

endmodule

// File: rtl/lane_drive.sv
module lane_drive #(
  parameter int unsigned LANES = 4,
  localparam int unsigned CW = $clog2(LANES) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             snoop_off,
  input  logic [LANES-1:0] reg_mask,
  input  logic [CW-1:0]    lane_cnt,
  input  logic             d3,
  output logic [LANES-1:0] lane_en
);

  logic [LANES-1:0] want;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign want[i] = !d3 && (lane_cnt > CW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) lane_en <= '1;
    else     lane_en <= snoop_off ? reg_mask : want;
  end

  // R4
  d3_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (!snoop_off && d3) |=> (lane_en == '0));

  // R8
  mask_follow_chk: assert property (@(posedge clk) disable iff (rst)
    snoop_off |=> (lane_en == $past(reg_mask)));

endmodule

// File: rtl/aux_lane_snoop.sv
module aux_lane_snoop
  import aux_snoop_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter logic [AUX_ADDR_W-1:0] LC_ADDR = 20'h00101,
  parameter logic [AUX_ADDR_W-1:0] PS_ADDR = 20'h00600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_sot,
  input  logic             rx_eot,
  input  logic [7:0]       rx_byte,
  input  logic             snoop_off,
  input  logic [LANES-1:0] reg_lane_mask,
  output logic [LANES-1:0] lane_en
);

  localparam int unsigned CW = $clog2(LANES) + 1;

  logic          commit_lc, commit_ps, d3;
  logic [4:0]    lc_val;
  logic [2:0]    ps_val;
  logic [CW-1:0] lane_cnt;

  aux_req_parse #(.LC_ADDR(LC_ADDR), .PS_ADDR(PS_ADDR)) u_parse (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sot(rx_sot), .rx_eot(rx_eot),
    .rx_byte(rx_byte), .commit_lc_o(commit_lc), .lc_val_o(lc_val),
    .commit_ps_o(commit_ps), .ps_val_o(ps_val)
  );

  snoop_shadow #(.LANES(LANES)) u_shadow (
    .clk(clk), .rst(rst), .hold(snoop_off), .commit_lc(commit_lc), .lc_val(lc_val),
    .commit_ps(commit_ps), .ps_val(ps_val), .lane_cnt_o(lane_cnt), .d3_o(d3)
  );

  lane_drive #(.LANES(LANES)) u_drive (
    .clk(clk), .rst(rst), .snoop_off(snoop_off), .reg_mask(reg_lane_mask),
    .lane_cnt(lane_cnt), .d3(d3), .lane_en(lane_en)
  );

endmodule

// File: tb/aux_lane_snoop_tb.sv
module aux_lane_snoop_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       rx_valid, rx_sot, rx_eot;
  logic [7:0] rx_byte;
  logic       snoop_off;
  logic [3:0] reg_lane_mask;
  logic [3:0] lane_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  aux_lane_snoop dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sot(rx_sot), .rx_eot(rx_eot),
    .rx_byte(rx_byte), .snoop_off(snoop_off), .reg_lane_mask(reg_lane_mask),
    .lane_en(lane_en)
  );

  typedef struct packed {
    logic [3:0]  cmd;
    logic [19:0] addr;
    logic [1:0]  nd;
    logic [23:0] data;
    logic        trunc;
    logic [3:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{4'h8, 20'h00101, 2'd1, 24'h020000, 1'b0, 4'b0011, 4'd2}, // R2 count 2
    '{4'h8, 20'h00101, 2'd1, 24'h010000, 1'b0, 4'b0001, 4'd2}, // R2 count 1
    '{4'h8, 20'h00101, 2'd1, 24'h030000, 1'b0, 4'b0001, 4'd3}, // R3 illegal 3
    '{4'h8, 20'h00101, 2'd1, 24'hE40000, 1'b0, 4'b1111, 4'd3}, // R3 high bits ignored
    '{4'h9, 20'h00101, 2'd1, 24'h010000, 1'b0, 4'b1111, 4'd6}, // R6 read
    '{4'h8, 20'h00600, 2'd1, 24'h020000, 1'b0, 4'b0000, 4'd4}, // R4 sleep 2
    '{4'h8, 20'h00101, 2'd1, 24'h010000, 1'b0, 4'b0000, 4'd4}, // R4 count kept dark
    '{4'h8, 20'h00600, 2'd1, 24'h010000, 1'b0, 4'b0001, 4'd4}, // R4 wake
    '{4'h8, 20'h00600, 2'd1, 24'h0D0000, 1'b0, 4'b0000, 4'd4}, // R4 sleep 5
    '{4'h8, 20'h005FF, 2'd3, 24'h000100, 1'b0, 4'b0001, 4'd5}, // R5 burst over power
    '{4'h8, 20'h00100, 2'd3, 24'h000200, 1'b0, 4'b0011, 4'd5}, // R5 burst over count
    '{4'h8, 20'h00101, 2'd1, 24'h040000, 1'b1, 4'b0011, 4'd7}, // R7 truncated
    '{4'h8, 20'h00102, 2'd1, 24'h010000, 1'b0, 4'b0011, 4'd5}, // R5 neighbour
    '{4'h0, 20'h00101, 2'd1, 24'h040000, 1'b0, 4'b0011, 4'd6}  // R6 i2c write
  };

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s lane_en=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic s, input logic e);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b; rx_sot = s; rx_eot = e;
  endtask

  task automatic idle();
    @(negedge clk);
    rx_valid = 1'b0; rx_sot = 1'b0; rx_eot = 1'b0; rx_byte = 8'h00;
  endtask

  task automatic send(input vec_t v);
    put({v.cmd, v.addr[19:16]}, 1'b1, 1'b0);
    put(v.addr[15:8], 1'b0, 1'b0);
    put(v.addr[7:0], 1'b0, 1'b0);
    put(8'(v.nd) - 8'd1, 1'b0, 1'b0);
    for (int k = 0; k < int'(v.nd); k++)
      put(v.data[23 - 8*k -: 8], 1'b0, (k == int'(v.nd) - 1) && !v.trunc);
    if (v.trunc) begin
      put(8'h90, 1'b1, 1'b0);
      put(8'h01, 1'b0, 1'b0);
      put(8'h01, 1'b0, 1'b0);
      put(8'h00, 1'b0, 1'b1);
    end
    idle();
  endtask

  function automatic vec_t wr1(input logic [19:0] a, input logic [7:0] d);
    return '{4'h8, a, 2'd1, {d, 16'h0}, 1'b0, 4'b0000, 4'd0};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; rx_valid = 0; rx_sot = 0; rx_eot = 0; rx_byte = 0;
    snoop_off = 0; reg_lane_mask = 4'b0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", lane_en, 4'b1111);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), lane_en, VEC[i].exp);
    end

    // R2 latency: old value one edge after commit, new value after the second
    send(wr1(20'h00101, 8'h04));
    check("R2 latency hold", lane_en, 4'b0011);
    @(negedge clk);
    check("R2 latency update", lane_en, 4'b1111);

    // R8 mask control
    snoop_off = 1'b1; reg_lane_mask = 4'b1010;
    @(negedge clk);
    check("R8 mask taken", lane_en, 4'b1010);
    send(wr1(20'h00101, 8'h01));
    @(negedge clk);
    check("R8 count write ignored", lane_en, 4'b1010);
    send(wr1(20'h00600, 8'h02));
    @(negedge clk);
    check("R8 sleep write ignored", lane_en, 4'b1010);
    reg_lane_mask = 4'b0101;
    @(negedge clk);
    check("R8 mask change", lane_en, 4'b0101);
    snoop_off = 1'b0;
    @(negedge clk);
    check("R8 snoop restored", lane_en, 4'b1111);

    // R1 mid-run reset
    send(wr1(20'h00101, 8'h01));
    @(negedge clk);
    check("R2 before reset", lane_en, 4'b0001);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run reset", lane_en, 4'b1111);
    @(negedge clk);
    check("R1 reset held", lane_en, 4'b1111);

    finish_run();
  end

endmodule